// File: doc/BRIEF.md
# Sequence-Numbered Line Memory Responder

This block is the memory side of a cache-to-memory link that transfers whole 512-bit lines. A requester presents a request code, a 4-bit sequence number, separate load and store line addresses, and a 512-bit store line. The responder performs the operation on a small internal line array and answers with a response code, the sequence number of the request it is serving, and a 512-bit load line.

A new request is recognised because its sequence number differs from the one last accepted. The requester does not have to return to an idle code and wait for a ready answer between requests, so transfers can follow each other directly. A swap reads the old line at the load address and writes the new line at the store address in a single transaction. The array has a configurable number of lines and a configurable service latency, and any address outside the array is refused with a failure code.

Top module: `line_req_responder`

## Requirements
- R1: After reset the response code is READY, the echoed sequence is 0 and the load line is all zero. Response codes: READY=0, OK=1, HOLD=2, FAIL=3.
- R2: A request whose code is not IDLE is accepted when it is the first since reset or when its sequence number differs from the last accepted one. From the cycle after acceptance the response is HOLD with the new sequence number echoed. Request codes: IDLE=0, LOAD=1, STORE=2, SWAP=3.
- R3: A request that presents the sequence number of the last accepted one is not executed again: a finished response stays as it is, and after READY the response stays READY.
- R4: HOLD is shown for exactly LAT cycles, after which the response becomes OK or FAIL with the same sequence number.
- R5: LOAD returns on OK the line stored at the load address.
- R6: STORE writes the store line at the store address and returns an all-zero load line with OK.
- R7: SWAP returns the line at the load address as it was before the transaction, then writes the store line at the store address; with equal addresses the old content is returned.
- R8: A request whose used address (load address for LOAD, store address for STORE, either for SWAP) is DEPTH or more returns FAIL with an all-zero load line, and no line of the array changes.
- R9: When the requester presents IDLE after a finished request, the response returns to READY on the next cycle and keeps echoing the last sequence number.
- R10: The sequence number wraps from 15 to 0, and 0 after 15 counts as a new request.
- R11: A new request presented while the previous result is shown is accepted directly, with no READY in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_code | input | 2 | Request code: IDLE, LOAD, STORE, SWAP |
| req_seq | input | 4 | Request sequence number |
| ld_addr | input | ADDR_W | Line address read by LOAD and SWAP |
| st_addr | input | ADDR_W | Line address written by STORE and SWAP |
| st_data | input | LINE_W | Line written by STORE and SWAP |
| rsp_code | output | 2 | Response code: READY, OK, HOLD, FAIL |
| rsp_seq | output | 4 | Sequence number of the request being served |
| ld_data | output | LINE_W | Line returned by LOAD and SWAP |

## Verification
Two functions meet in one clock edge: the read and the write of a swap, and the end of one result together with the acceptance of the next request. The bench provokes the first by swapping a line onto itself and onto another line, judging that the returned line is the old one and that a following load sees the new one. It provokes the second by presenting the next sequence number in the very cycle an OK is visible, and judges that HOLD follows directly with no READY and that a repeated sequence number is never executed twice.

// File: rtl/line_req_responder.sv
module line_req_responder #(
  parameter int LINE_W = 512,
  parameter int ADDR_W = 6,
  parameter int DEPTH  = 40,
  parameter int LAT    = 3,
  parameter int SEQ_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        req_code,
  input  logic [SEQ_W-1:0]  req_seq,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [LINE_W-1:0] st_data,
  output logic [1:0]        rsp_code,
  output logic [SEQ_W-1:0]  rsp_seq,
  output logic [LINE_W-1:0] ld_data
);
  localparam logic [1:0] RQ_IDLE = 2'd0;
  localparam logic [1:0] RS_READY = 2'd0, RS_OK = 2'd1, RS_HOLD = 2'd2, RS_FAIL = 2'd3;
  localparam int CNT_W = $clog2(LAT + 1);
  localparam logic [ADDR_W:0] LIM = (ADDR_W + 1)'(DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_DONE} state_t;

  state_t             st;
  logic               seen;
  logic [SEQ_W-1:0]   last_seq;
  logic [1:0]         op;
  logic [ADDR_W-1:0]  la, sa;
  logic [LINE_W-1:0]  sd, ld_q;
  logic [CNT_W-1:0]   cnt;
  logic [1:0]         code_q;
  logic [LINE_W-1:0]  mem [DEPTH];

  wire take   = (req_code != RQ_IDLE) && (!seen || req_seq != last_seq) && (st != S_BUSY);
  wire ld_bad = op[0] && ({1'b0, la} >= LIM);
  wire st_bad = op[1] && ({1'b0, sa} >= LIM);
  wire bad    = ld_bad || st_bad;
  wire finish = (st == S_BUSY) && (cnt == '0);

  assign rsp_code = code_q;
  assign rsp_seq  = last_seq;
  assign ld_data  = ld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      seen     <= 1'b0;
      last_seq <= '0;
      op       <= '0;
      la       <= '0;
      sa       <= '0;
      sd       <= '0;
      cnt      <= '0;
      code_q   <= RS_READY;
      ld_q     <= '0;
    end else begin
      case (st)
        S_BUSY: begin
          if (!finish) cnt <= cnt - 1'b1;
          else begin
            st <= S_DONE;
            if (bad) begin
              code_q <= RS_FAIL;
              ld_q   <= '0;
            end else begin
              code_q <= RS_OK;
              ld_q   <= op[0] ? mem[la] : '0;
            end
          end
        end
        default: begin
          if (take) begin
            st       <= S_BUSY;
            seen     <= 1'b1;
            last_seq <= req_seq;
            op       <= req_code;
            la       <= ld_addr;
            sa       <= st_addr;
            sd       <= st_data;
            cnt      <= CNT_W'(LAT - 1);
            code_q   <= RS_HOLD;
            ld_q     <= '0;
          end else if (st == S_DONE && req_code == RQ_IDLE) begin
            st     <= S_IDLE;
            code_q <= RS_READY;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && finish && !bad && op[1]) mem[sa] <= sd;
  end
endmodule

module line_req_responder_chk #(
  parameter int SEQ_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       req_code,
  input logic [SEQ_W-1:0] req_seq,
  input logic [1:0]       rsp_code,
  input logic [SEQ_W-1:0] rsp_seq
);
  localparam logic [1:0] RQ_IDLE = 2'd0;
  localparam logic [1:0] RS_READY = 2'd0, RS_OK = 2'd1, RS_HOLD = 2'd2, RS_FAIL = 2'd3;

  p_new_seq_accepted_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_code != RS_HOLD && req_code != RQ_IDLE && req_seq != rsp_seq) |=>
      (rsp_code == RS_HOLD && rsp_seq == $past(req_seq)));

  p_same_seq_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_code == RS_OK && req_code != RQ_IDLE && req_seq == rsp_seq) |=> (rsp_code == RS_OK));

  p_hold_seq_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_code == RS_HOLD) |=> (rsp_seq == $past(rsp_seq) && rsp_code != RS_READY));

  p_idle_to_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((rsp_code == RS_OK || rsp_code == RS_FAIL) && req_code == RQ_IDLE) |=>
      (rsp_code == RS_READY && $stable(rsp_seq)));
endmodule

bind line_req_responder line_req_responder_chk #(.SEQ_W(SEQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_code(req_code), .req_seq(req_seq),
  .rsp_code(rsp_code), .rsp_seq(rsp_seq)
);

// File: tb/tb_line_req_responder.sv
module tb_line_req_responder;
  localparam int CLK_P  = 10;
  localparam int LINE_W = 512;
  localparam int ADDR_W = 6;
  localparam int DEPTH  = 40;
  localparam int LAT    = 3;

  localparam logic [1:0] Q_IDLE = 2'd0, Q_LOAD = 2'd1, Q_STORE = 2'd2, Q_SWAP = 2'd3;
  localparam logic [1:0] A_READY = 2'd0, A_OK = 2'd1, A_HOLD = 2'd2, A_FAIL = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] req_code = Q_IDLE;
  logic [3:0] req_seq = '0;
  logic [ADDR_W-1:0] ld_addr = '0, st_addr = '0;
  logic [LINE_W-1:0] st_data = '0;
  logic [1:0] rsp_code;
  logic [3:0] rsp_seq;
  logic [LINE_W-1:0] ld_data;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;
  logic [3:0] seq = 4'd0;

  always #(CLK_P/2) clk = ~clk;

  line_req_responder #(.LINE_W(LINE_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .req_code(req_code), .req_seq(req_seq),
    .ld_addr(ld_addr), .st_addr(st_addr), .st_data(st_data),
    .rsp_code(rsp_code), .rsp_seq(rsp_seq), .ld_data(ld_data));

  function automatic logic [LINE_W-1:0] pat(int k);
    logic [LINE_W-1:0] r;
    for (int i = 0; i < LINE_W/32; i++)
      r[i*32 +: 32] = (32'(k) * 32'h0101_0101) ^ (32'(i) * 32'h0010_0007) ^ 32'hC3A5_0000;
    return r;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [LINE_W-1:0] act, logic [LINE_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] code, input logic [ADDR_W-1:0] la, input logic [ADDR_W-1:0] sa,
                     input logic [LINE_W-1:0] d, input logic [1:0] exp_code,
                     input logic [LINE_W-1:0] exp_data, input string req);
    int holds = 0;
    seq = seq + 4'd1;
    req_code = code; req_seq = seq; ld_addr = la; st_addr = sa; st_data = d;
    @(negedge clk);
    chk(rsp_code == A_HOLD && rsp_seq == seq, "R2", "hold with echoed seq",
        {rsp_code, rsp_seq}, {A_HOLD, seq});
    while (rsp_code == A_HOLD && holds < 50) begin
      holds++;
      @(negedge clk);
    end
    chk(holds == LAT, "R4", "hold length", holds, LAT);
    chk(rsp_code == exp_code && rsp_seq == seq, req, "result code/seq",
        {rsp_code, rsp_seq}, {exp_code, seq});
    chk(ld_data == exp_data, req, "load line", ld_data, exp_data);
  endtask

  task automatic t_reset;
    chk(rsp_code == A_READY && rsp_seq == 4'd0 && ld_data == '0, "R1", "reset state",
        {rsp_code, rsp_seq, ld_data[7:0]}, '0);
  endtask

  task automatic t_store_load;
    run(Q_STORE, 0, 3, pat(3), A_OK, '0, "R6");
    @(negedge clk);
    chk(rsp_code == A_OK && rsp_seq == seq, "R3", "same seq not rerun", rsp_code, A_OK);
    run(Q_STORE, 0, 5, pat(5), A_OK, '0, "R11");
    run(Q_LOAD, 3, 0, '0, A_OK, pat(3), "R5");
    run(Q_LOAD, 5, 0, '0, A_OK, pat(5), "R5");
  endtask

  task automatic t_swap;
    run(Q_SWAP, 3, 3, pat(30), A_OK, pat(3), "R7");
    run(Q_LOAD, 3, 0, '0, A_OK, pat(30), "R7");
    run(Q_SWAP, 3, 5, pat(50), A_OK, pat(30), "R7");
    run(Q_LOAD, 5, 0, '0, A_OK, pat(50), "R7");
    run(Q_LOAD, 3, 0, '0, A_OK, pat(30), "R7");
  endtask

  task automatic t_fail;
    run(Q_LOAD, 45, 0, '0, A_FAIL, '0, "R8");
    run(Q_SWAP, 5, 50, pat(77), A_FAIL, '0, "R8");
    run(Q_SWAP, 63, 3, pat(77), A_FAIL, '0, "R8");
    run(Q_STORE, 0, DEPTH, pat(78), A_FAIL, '0, "R8");
    run(Q_LOAD, 5, 0, '0, A_OK, pat(50), "R8");
    run(Q_LOAD, 3, 0, '0, A_OK, pat(30), "R8");
    run(Q_STORE, 0, DEPTH-1, pat(39), A_OK, '0, "R8");
    run(Q_LOAD, DEPTH-1, 0, '0, A_OK, pat(39), "R8");
  endtask

  task automatic t_idle;
    req_code = Q_IDLE;
    @(negedge clk);
    chk(rsp_code == A_READY && rsp_seq == seq, "R9", "ready after idle", {rsp_code, rsp_seq}, {A_READY, seq});
    req_code = Q_LOAD; ld_addr = 3;
    @(negedge clk);
    @(negedge clk);
    chk(rsp_code == A_READY, "R3", "repeated seq after ready ignored", rsp_code, A_READY);
  endtask

  task automatic t_wrap;
    while (seq != 4'd14) run(Q_LOAD, 5, 0, '0, A_OK, pat(50), "R10");
    run(Q_LOAD, 3, 0, '0, A_OK, pat(30), "R10");
    chk(seq == 4'd15, "R10", "seq at top", seq, 4'd15);
    run(Q_LOAD, 5, 0, '0, A_OK, pat(50), "R10");
    chk(rsp_seq == 4'd0, "R10", "wrapped seq echoed", rsp_seq, 4'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000 && !done) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    seq = 4'hF;
    t_store_load();
    t_swap();
    t_fail();
    t_idle();
    t_wrap();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule